// File: doc/BRIEF.md
# Latched Serial Gain-Control Register

This block turns a three-wire serial stream into a parallel gain word for a step attenuator. A serial clock, a serial data line and a latch strobe arrive from outside the system clock domain. All three are resynchronised to the system clock. A data bit is shifted in on each rising edge of the resynchronised serial clock while the strobe is low. A rising edge of the strobe then copies the shift register into the parallel output register.

The control word is active-low and binary weighted. A bit at 1 leaves its attenuation stage bypassed. A bit at 0 inserts a step of 2^i half-dB. The all-ones code is therefore maximum gain, and the all-zeros code, which reset selects, is minimum gain. The block also reports the total attenuation in half-dB units. A serial output follows the shift register's top bit, so several blocks can be chained and the shifted contents can be read back. A strobe that arrives before a full word has been clocked in is rejected and raises a sticky flag.

Top module: `gain_serial_reg`

## Requirements
- R1: While reset is high and on the first cycle after it, gain_code is all zeros, atten_half_db is 2^WORD_W-1 (63 for six bits), short_frame is 0 and sdo is 0.
- R2: Each synchronised rising edge of sclk_in, taken while le_in is low, shifts sdata_in into bit 0 of the shift register and moves the older bits one place toward the MSB. The first bit sent therefore ends up in the MSB.
- R3: While the synchronised le_in is high, sclk_in edges do not change the shift register and are not counted toward a frame.
- R4: On a synchronised rising edge of le_in, if at least WORD_W accepted sclk edges have occurred since the last accepted load, gain_code takes the shift register's value and the edge count restarts.
- R5: A rising edge of le_in that comes after fewer than WORD_W accepted edges leaves gain_code unchanged and sets short_frame. The flag stays at 1 until reset.
- R6: atten_half_db equals 2^WORD_W-1 minus gain_code. Each bit i at 0 adds 2^i half-dB: code 000001 gives 62 and code 100000 gives 31.
- R7: sdo always equals the current MSB of the shift register.
- R8: gain_code changes only in the cycle after a synchronised rising edge of le_in, or by reset.
- R9: Every code is legal. When more than WORD_W bits are shifted before a load, the last WORD_W bits sent form the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Asynchronous serial clock |
| sdata_in | input | 1 | Asynchronous serial data, MSB first |
| le_in | input | 1 | Asynchronous latch strobe; its high level blocks shifting |
| gain_code | output | WORD_W | Latched active-low attenuation code |
| atten_half_db | output | WORD_W | Total attenuation in 0.5 dB units |
| sdo | output | 1 | MSB of the shift register |
| short_frame | output | 1 | Sticky flag for a rejected short frame |

## Verification
The bench builds the block with its default six-bit word and two synchroniser stages. With these values, every one of the 64 codes maps to an attenuation the bench can compute by hand, including both extremes, 0 and 63. The short word also keeps frames of fewer bits, exactly six bits and more than six bits short enough to run as separate directed scenarios. The bench holds each serial level for several system clocks, which covers the synchroniser latency. It reads back the shifted data through sdo.

// File: rtl/gain_serial_reg_pkg.sv
package gain_serial_reg_pkg;

    localparam int DEF_WORD_W   = 6;
    localparam int DEF_SYNC_LEN = 2;

    // resynchronised view of the three serial pins
    typedef struct packed {
        logic sclk;
        logic sdata;
        logic strobe;
    } ser_pins_t;

    // decoded events derived from the resynchronised pins
    typedef struct packed {
        logic shift_go;   // accepted serial clock edge
        logic load_go;    // strobe rising edge
        logic strobe_lvl; // strobe level
        logic bit_val;    // data bit aligned with shift_go
    } ser_evt_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/gr_sync.sv
module gr_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d_async,
    output logic [N-1:0] d_sync
);
    logic [N-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d_async;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/gr_edge.sv
module gr_edge
    import gain_serial_reg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ser_pins_t pins,
    output ser_evt_t  evt
);
    ser_pins_t prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= pins;
    end

    always_comb begin
        evt.strobe_lvl = pins.strobe;
        evt.bit_val    = pins.sdata;
        evt.shift_go   = pins.sclk & ~prev.sclk & ~pins.strobe;
        evt.load_go    = pins.strobe & ~prev.strobe;
    end
endmodule

// File: rtl/gr_shift.sv
module gr_shift #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_go,
    input  logic         bit_val,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst)           word <= '0;
        else if (shift_go) word <= {word[W-2:0], bit_val};
    end
endmodule

// File: rtl/gr_load.sv
module gr_load #(
    parameter int W  = 6,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift_go,
    input  logic          load_go,
    input  logic [W-1:0]  word,
    output logic [W-1:0]  code,
    output logic [CW-1:0] edge_cnt,
    output logic          short_flag
);
    localparam logic [CW-1:0] FULL = CW'(W);
    logic full_frame;

    assign full_frame = (edge_cnt == FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            code       <= '0;
            edge_cnt   <= '0;
            short_flag <= 1'b0;
        end else begin
            if (load_go) begin
                if (full_frame) begin
                    code     <= word;
                    edge_cnt <= '0;
                end else begin
                    short_flag <= 1'b1;
                end
            end else if (shift_go && !full_frame) begin
                edge_cnt <= edge_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/gain_serial_reg.sv
module gain_serial_reg
    import gain_serial_reg_pkg::*;
#(
    parameter int WORD_W   = DEF_WORD_W,
    parameter int SYNC_LEN = DEF_SYNC_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_in,
    input  logic              sdata_in,
    input  logic              le_in,
    output logic [WORD_W-1:0] gain_code,
    output logic [WORD_W-1:0] atten_half_db,
    output logic              sdo,
    output logic              short_frame
);
    localparam int CW = cnt_width(WORD_W);
    localparam logic [WORD_W-1:0] MAX_CODE = '1;

    ser_pins_t         pins_raw, pins_s;
    ser_evt_t          evt;
    logic [WORD_W-1:0] shreg;
    logic [CW-1:0]     edge_cnt;
    logic              le_s, le_rise;

    assign pins_raw = '{sclk: sclk_in, sdata: sdata_in, strobe: le_in};

    gr_sync #(.N($bits(ser_pins_t)), .STAGES(SYNC_LEN)) u_sync (
        .clk(clk), .rst(rst), .d_async(pins_raw), .d_sync(pins_s)
    );

    gr_edge u_edge (.clk(clk), .rst(rst), .pins(pins_s), .evt(evt));

    gr_shift #(.W(WORD_W)) u_shift (
        .clk(clk), .rst(rst), .shift_go(evt.shift_go),
        .bit_val(evt.bit_val), .word(shreg)
    );

    gr_load #(.W(WORD_W), .CW(CW)) u_load (
        .clk(clk), .rst(rst), .shift_go(evt.shift_go), .load_go(evt.load_go),
        .word(shreg), .code(gain_code), .edge_cnt(edge_cnt),
        .short_flag(short_frame)
    );

    assign le_s          = evt.strobe_lvl;
    assign le_rise       = evt.load_go;
    assign sdo           = shreg[WORD_W-1];
    assign atten_half_db = MAX_CODE - gain_code;
endmodule

// File: rtl/gain_serial_reg_chk.sv
module gain_serial_reg_chk #(
    parameter int W  = 6,
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          le_lvl,
    input logic          le_rise,
    input logic [CW-1:0] edge_cnt,
    input logic [W-1:0]  gain_code,
    input logic          short_frame,
    input logic          sdo
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (gain_code == '0) && !short_frame && !sdo);

    p_hold_while_latched_r3: assert property (@(posedge clk) disable iff (rst)
        le_lvl |=> $stable(sdo));

    p_short_rejected_r5: assert property (@(posedge clk) disable iff (rst)
        (le_rise && (edge_cnt < CW'(W))) |=> $stable(gain_code) && short_frame);

    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        short_frame |=> short_frame);

    p_code_only_on_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        !le_rise |=> $stable(gain_code));
endmodule

bind gain_serial_reg gain_serial_reg_chk #(.W(WORD_W), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .le_lvl(le_s), .le_rise(le_rise),
    .edge_cnt(edge_cnt), .gain_code(gain_code),
    .short_frame(short_frame), .sdo(sdo)
);

// File: tb/sim_gain_serial_reg.sv
module sim_gain_serial_reg;
    localparam int W = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sclk_in = 1'b0, sdata_in = 1'b0, le_in = 1'b0;
    logic [W-1:0] gain_code, atten_half_db;
    logic         sdo, short_frame;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gain_serial_reg #(.WORD_W(W), .SYNC_LEN(2)) u0 (
        .clk(clk), .rst(rst), .sclk_in(sclk_in), .sdata_in(sdata_in),
        .le_in(le_in), .gain_code(gain_code), .atten_half_db(atten_half_db),
        .sdo(sdo), .short_frame(short_frame)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdata_in = b; sclk_in = 1'b0; idle(4);
        sclk_in = 1'b1; idle(4);
        sclk_in = 1'b0; idle(2);
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic pulse_le();
        le_in = 1'b1; idle(6);
        le_in = 1'b0; idle(6);
    endtask

    task automatic load_and_check(input logic [W-1:0] w);
        send_bits(16'(w), W);
        check("R7 sdo shows first bit sent", sdo, w[W-1]);
        pulse_le();
        check("R4 code loaded", gain_code, w);
        check("R6 attenuation", atten_half_db, 63 - int'(w));
    endtask

    task automatic t_reset();
        rst = 1'b1; idle(3);
        check("R1 code at reset", gain_code, 0);
        check("R1 atten at reset", atten_half_db, 63);
        check("R1 flag at reset", short_frame, 0);
        check("R1 sdo at reset", sdo, 0);
        rst = 1'b0; idle(2);
    endtask

    task automatic t_codes();
        load_and_check(6'b111111);
        load_and_check(6'b000001);
        load_and_check(6'b100000);
        load_and_check(6'b101010);
        load_and_check(6'b000000);
        check("R5 no flag after full frames", short_frame, 0);
    endtask

    task automatic t_shift_order();
        // R2: MSB first; R9: seventh bit pushes out the first
        send_bits(16'b101101, 6);
        check("R2 first bit reached MSB", sdo, 1);
        send_bit(1'b0);
        check("R2 next bit moved to MSB", sdo, 0);
        check("R8 code unchanged while shifting", gain_code, 0);
        pulse_le();
        check("R9 last six bits kept", gain_code, 6'b011010);
    endtask

    task automatic t_gating();
        send_bits(16'b110011, 6);
        le_in = 1'b1; idle(6);
        check("R4 loaded before gating", gain_code, 6'b110011);
        for (int i = 0; i < 6; i++) begin
            sdata_in = 1'b0; sclk_in = 1'b1; idle(4);
            sclk_in = 1'b0; idle(4);
        end
        check("R3 sdo held while latched", sdo, 1);
        le_in = 1'b0; idle(6);
        pulse_le();
        check("R3 gated edges not counted, code kept", gain_code, 6'b110011);
        check("R5 short frame flagged", short_frame, 1);
    endtask

    task automatic t_short_accum();
        send_bits(16'b011, 3);
        pulse_le();
        check("R5 short load dropped", gain_code, 6'b110011);
        send_bits(16'b000111, 6);
        pulse_le();
        check("R4 count carries across rejected strobe", gain_code, 6'b000111);
        check("R5 flag stays set", short_frame, 1);
    endtask

    initial begin
        idle(2);
        t_reset();
        t_codes();
        t_shift_order();
        t_gating();
        t_short_accum();
        t_reset();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule